// File: doc/BRIEF.md
# External Interrupt Edge Detector with Lockout

This block gathers five external interrupt sources into a single pending flag. One dedicated pin is active low. Four port pins are active high. Every pin passes through a two-flop synchroniser. An interrupt is taken only when a source becomes active while all five sources were idle in the previous cycle. After one source has fired, activity on any other source is ignored until every pin is back at its idle level. This includes a port pin rising while the dedicated pin is held low, and the dedicated pin falling while a port pin is held high.

The CPU sees the block as one byte-wide register on a simple address/data bus. The register holds the pending flag, a write-one-to-clear control, the interrupt enable and two oscillator select bits. The oscillator select bits are only stored and driven out. The CPU interrupt request is a registered copy of the pending flag ANDed with the enable.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the register at address 0x0D reads 0x06. That is enable (bit 2) = 1, oscillator select = 2'b10 (bits 1:0), and the pending flag (bit 6) = 0. The `osc_sel` output is 2'b10 and `cpu_irq` is 0.
- R2: A falling edge on `irq_n_pin` while all sources are idle sets the pending flag, which reads back as bit 6.
- R3: A rising edge on any `port_irq` bit while all sources are idle sets the pending flag.
- R4: While any port pin is high, a falling `irq_n_pin` and rising edges on other port pins do not set the flag.
- R5: While `irq_n_pin` is low, rising port pins do not set the flag, even after `irq_n_pin` returns high while a port pin is still high.
- R6: Once every source has returned to idle, the next activation on any source sets the flag again.
- R7: A write to 0x0D with bit 7 = 1 clears the pending flag. With bit 7 = 0, the flag is left as it was.
- R8: When a qualified edge and a clearing write fall in the same cycle, the flag ends up set.
- R9: `cpu_irq` equals the pending flag AND the enable bit, delayed by one register stage. The flag is still set while the enable bit is 0.
- R10: Bits 7 and 5:3 always read 0, and writes to bit 6 do not change the flag. Reads from any other address return 0x00, and writes to any other address change nothing.
- R11: Bits 1:0 are read/write storage that drives `osc_sel`. Writing them leaves the pending flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n_pin | input | 1 | Dedicated active-low interrupt pin (asynchronous) |
| port_irq | input | 4 | Active-high port interrupt pins (asynchronous) |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on the next cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| osc_sel | output | 2 | Oscillator select bits |

## Verification
The bench targets cross-source lockout. It holds one source active and then activates the others. A detector that treats each pin separately would raise the flag again in this case. The bench also releases the dedicated pin while a port pin stays high. A design that re-arms on a single source going idle would fire on that release. It places a clearing write in exactly the cycle a synchronised edge qualifies, so a design that gives the clear priority reads back 0x06 instead of 0x46. It also raises the flag with the enable off, then writes bit 7 = 0, to expose a design that drops the flag on any write or gates the flag itself rather than the request.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam int CLR_BIT  = 7;
  localparam int FLAG_BIT = 6;
  localparam int EN_BIT   = 2;
  localparam int OSC_W    = 2;
  localparam logic [OSC_W-1:0] OSC_RST = 2'b10;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[g]}};
        else     chain <= {chain[STAGES-2:0], d_in[g]};
      end
      assign q_out[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
  parameter int NUM_PORT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pin_n_s,
  input  logic [NUM_PORT-1:0] port_s,
  output logic                trig
);
  localparam int NSRC = NUM_PORT + 1;

  logic [NSRC-1:0] active;
  logic [NSRC-1:0] active_q;

  // every source mapped to "1 = asserted"
  assign active = {~pin_n_s, port_s};

  always_ff @(posedge clk) begin
    if (rst) active_q <= '0;
    else     active_q <= active;
  end

  // trigger only leaving the all-idle state: any source held active locks out the rest
  assign trig = ~(|active_q) & (|active);
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              flag,
  output logic              en,
  output logic [OSC_W-1:0]  osc
);
  logic hit_wr;
  logic clr_req;
  logic [DATA_W-1:0] rd_view;
  logic unused_wbits;

  assign hit_wr  = bus_wr && (bus_addr == REG_ADDR);
  assign clr_req = hit_wr && bus_wdata[CLR_BIT];
  assign unused_wbits = ^bus_wdata[FLAG_BIT:EN_BIT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      en   <= 1'b1;
      osc  <= OSC_RST;
    end else begin
      // a qualified edge beats a clear in the same cycle
      if (trig)         flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
      if (hit_wr) begin
        en  <= bus_wdata[EN_BIT];
        osc <= bus_wdata[OSC_W-1:0];
      end
    end
  end

  always_comb begin
    rd_view           = '0;
    rd_view[FLAG_BIT] = flag;
    rd_view[EN_BIT]   = en;
    rd_view[OSC_W-1:0] = osc;
  end

  always_ff @(posedge clk) begin
    if (rst)                               bus_rdata <= '0;
    else if (bus_rd && bus_addr == REG_ADDR) bus_rdata <= rd_view;
    else                                   bus_rdata <= '0;
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_PORT = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0D
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                irq_n_pin,
  input  logic [NUM_PORT-1:0] port_irq,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                cpu_irq,
  output logic [OSC_W-1:0]    osc_sel
);
  localparam int NSRC = NUM_PORT + 1;
  localparam logic [NSRC-1:0] SYNC_RST = {1'b1, {NUM_PORT{1'b0}}};

  logic [NSRC-1:0] src_s;
  logic trig;
  logic flag_w;
  logic en_w;

  ext_irq_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) sync_i (
    .clk(clk), .rst(rst), .d_in({irq_n_pin, port_irq}), .q_out(src_s)
  );

  ext_irq_detect #(.NUM_PORT(NUM_PORT)) det_i (
    .clk(clk), .rst(rst), .pin_n_s(src_s[NSRC-1]), .port_s(src_s[NUM_PORT-1:0]),
    .trig(trig)
  );

  ext_irq_regs #(.REG_ADDR(REG_ADDR)) regs_i (
    .clk(clk), .rst(rst), .trig(trig),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .flag(flag_w), .en(en_w), .osc(osc_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) cpu_irq <= 1'b0;
    else     cpu_irq <= flag_w & en_w;
  end
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk
  import ext_irq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0D
) (
  input logic              clk,
  input logic              rst,
  input logic              trig,
  input logic              flag_w,
  input logic              en_w,
  input logic              cpu_irq,
  input logic [OSC_W-1:0]  osc_sel,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (en_w && !flag_w && osc_sel == OSC_RST && !cpu_irq));

  // R9
  irq_follows_flag_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cpu_irq == $past(flag_w & en_w)));

  // R8
  edge_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    trig |=> flag_w);

  // R7
  clear_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_ADDR && bus_wdata[CLR_BIT] && !trig) |=> !flag_w);

  // R2
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_w) |-> $past(trig));

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[CLR_BIT] == 1'b0) && (bus_rdata[FLAG_BIT-1:EN_BIT+1] == '0));
endmodule

bind ext_irq_ctrl ext_irq_chk #(.REG_ADDR(REG_ADDR)) chk_i (
  .clk(clk), .rst(rst), .trig(trig), .flag_w(flag_w), .en_w(en_w),
  .cpu_irq(cpu_irq), .osc_sel(osc_sel), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] REG = 8'h0D;

  typedef struct {
    logic [7:0] exp;
    string      req;
  } rd_item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       irq_n_pin = 1'b1;
  logic [3:0] port_irq = '0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cpu_irq;
  logic [1:0] osc_sel;

  int checks = 0;
  int errors = 0;
  rd_item_t exp_q[$];
  logic rd_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_n_pin(irq_n_pin), .port_irq(port_irq),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .osc_sel(osc_sel)
  );

  // monitor: read issued in one cycle, compared on the following negedge
  always @(posedge clk) rd_q <= bus_rd;
  always @(negedge clk) begin
    if (rd_q) begin
      rd_item_t it;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s: read with empty scoreboard, actual %02h expected none", "R10", bus_rdata);
      end else begin
        it = exp_q.pop_front();
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: rdata actual %02h expected %02h", it.req, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back('{exp: e, req: req});
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] e, input string req);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset values
    chk({6'd0, osc_sel}, 8'h02, "R1");
    chk({7'd0, cpu_irq}, 8'h00, "R1");
    rd(REG, 8'h06, "R1");

    // R2 dedicated pin falling edge
    irq_n_pin = 1'b0; tick(5);
    rd(REG, 8'h46, "R2");
    chk({7'd0, cpu_irq}, 8'h01, "R9");
    irq_n_pin = 1'b1; tick(5);
    wr(REG, 8'h86); tick(1);
    rd(REG, 8'h06, "R7");

    // R3 port pin, R7 write of 0 to bit 7 keeps flag
    port_irq = 4'b0001; tick(5);
    rd(REG, 8'h46, "R3");
    wr(REG, 8'h06);
    rd(REG, 8'h46, "R7");
    port_irq = 4'b0000; tick(5);
    wr(REG, 8'h86);
    rd(REG, 8'h06, "R7");

    // R4 port held high locks out pin and other ports
    port_irq = 4'b0010; tick(5);
    wr(REG, 8'h86);
    irq_n_pin = 1'b0; port_irq = 4'b0110; tick(5);
    rd(REG, 8'h06, "R4");
    port_irq = 4'b0100; tick(5);
    rd(REG, 8'h06, "R4");
    irq_n_pin = 1'b1; port_irq = 4'b0000; tick(5);
    rd(REG, 8'h06, "R4");
    // R6 re-armed
    port_irq = 4'b1000; tick(5);
    rd(REG, 8'h46, "R6");
    port_irq = 4'b0000; tick(5);
    wr(REG, 8'h86);

    // R5 pin held low locks out ports
    irq_n_pin = 1'b0; tick(5);
    wr(REG, 8'h86);
    port_irq = 4'b0001; tick(5);
    rd(REG, 8'h06, "R5");
    irq_n_pin = 1'b1; tick(5);
    rd(REG, 8'h06, "R5");
    port_irq = 4'b0000; tick(5);
    irq_n_pin = 1'b0; tick(5);
    rd(REG, 8'h46, "R6");
    irq_n_pin = 1'b1; tick(5);
    wr(REG, 8'h86); tick(1);

    // R8 clear and qualified edge in the same cycle
    @(negedge clk); irq_n_pin = 1'b0;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = REG; bus_wdata = 8'h86;
    @(negedge clk); bus_wr = 1'b0;
    rd(REG, 8'h46, "R8");
    irq_n_pin = 1'b1; tick(5);
    wr(REG, 8'h86);

    // R9 flag sets with enable off, request follows enable
    wr(REG, 8'h02);
    port_irq = 4'b0001; tick(5);
    rd(REG, 8'h42, "R9");
    chk({7'd0, cpu_irq}, 8'h00, "R9");
    wr(REG, 8'h06); tick(2);
    chk({7'd0, cpu_irq}, 8'h01, "R9");
    port_irq = 4'b0000; tick(5);
    wr(REG, 8'h86); tick(2);
    chk({7'd0, cpu_irq}, 8'h00, "R9");

    // R10 reserved bits, flag not writable, other addresses
    wr(REG, 8'h7E);
    rd(REG, 8'h06, "R10");
    rd(8'h0C, 8'h00, "R10");
    wr(8'h0C, 8'h81);
    rd(REG, 8'h06, "R10");

    // R11 oscillator bits
    wr(REG, 8'h05);
    chk({6'd0, osc_sel}, 8'h01, "R11");
    rd(REG, 8'h05, "R11");
    port_irq = 4'b0100; tick(5);
    port_irq = 4'b0000; tick(5);
    wr(REG, 8'h04);
    rd(REG, 8'h44, "R11");
    chk({6'd0, osc_sel}, 8'h00, "R11");
    wr(REG, 8'h86);
    rd(REG, 8'h06, "R11");
    chk({6'd0, osc_sel}, 8'h02, "R11");

    tick(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10: pending reads actual %0d expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule